// File: doc/BRIEF.md
# Speculative Load Address Tracking Table

This block lets a core hoist loads above older stores that might write the same memory. The core issues a load early, which is called an advanced load. When it does, the block records the address, reduced to its 8-byte granule, in an entry tagged with the load's destination register. Every store the core performs is compared against all live entries, and so is every store seen on the external bus. An entry whose granule overlaps the bytes written is killed. Later the core sends a check request naming the register. One cycle after the request, the block answers whether the early value is still safe to use. If it is not, the core reissues the load or branches to recovery code. That follow-up action, and the data cache, sit outside this block.

An entry that has been displaced by replacement or cleared by a flush is simply invalid. A check on it gets the same unsafe answer as one hit by a store. When every entry is live and a new register arrives, the entry that was least recently inserted or successfully checked is replaced. A global flush input empties the table in one cycle.

All request inputs are qualified by a valid bit and are accepted in every cycle. The block never back-pressures, so it has no ready outputs. The response is a single-cycle `rsp_valid` pulse that the core must take when it appears.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is 0. A check for any register then answers `rsp_ok`=0.
- R2: A check request answers on the next cycle. In that cycle `rsp_valid`=1, `rsp_reg` echoes the requested register, and `rsp_ok`=1 if and only if a valid entry holds that register.
- R3: A core store (`st_valid`) writes 2^`st_size` bytes starting at `st_addr`, where `st_size` is 0 to 3. It invalidates every entry whose granule (address bits [ADDR_W-1:3]) equals the granule of the first byte or of the last byte written. An unaligned store therefore kills both granules it spans.
- R4: A bus store (`bus_valid`, `bus_addr`, `bus_size`) invalidates entries by the same rule as R3. It acts independently of, and in the same cycle as, a core store.
- R5: A store whose bytes fall entirely outside an entry's granule leaves that entry valid.
- R6: An advanced load to a register that already has a valid entry overwrites that entry's granule in place. After that, only the new granule is snooped for that register.
- R7: An advanced load to a register with no valid entry fills the lowest-numbered free entry. If every entry is valid, it replaces the entry least recently inserted or hit by a check. A later check of the displaced register answers 0.
- R8: When an advanced load and a store that hits the same entry or granule occur in the same cycle, the load wins and its entry is left valid.
- R9: `flush` invalidates all entries in one cycle. An advanced load in the same cycle is still installed.
- R10: When `chk_clear`=1, a check that finds a valid entry answers 1 and then invalidates that entry. Without `chk_clear` the entry stays valid.
- R11: A check sees the table as it was before the updates of its own cycle. A store, flush or load in the same cycle affects only later checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all entries |
| ld_valid | input | 1 | Advanced load insert request |
| ld_reg | input | REG_W | Destination register of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| st_valid | input | 1 | Core store snoop valid |
| st_addr | input | ADDR_W | Core store byte address |
| st_size | input | 2 | Core store size, 2^n bytes |
| bus_valid | input | 1 | Bus store snoop valid |
| bus_addr | input | ADDR_W | Bus store byte address |
| bus_size | input | 2 | Bus store size, 2^n bytes |
| chk_valid | input | 1 | Check request valid |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | Invalidate the entry on a successful check |
| rsp_valid | output | 1 | Check response valid |
| rsp_reg | output | REG_W | Register the response refers to |
| rsp_ok | output | 1 | 1 = speculation safe, 0 = redo the load or take recovery |

## Verification
The bench targets several corner cases. The first is an unaligned store that spills into the next granule: a design that compares only the start address would wrongly keep the entry alive. The second is a load and a store to the same granule in the same cycle: if the insert does not win, the fresh load is lost. The third is reinsertion of a live register: if the design allocated a second entry, two entries would claim the register and the old address would keep snooping. The fourth is a full table in which one entry has just been checked: a design that orders replacement by insertion alone would evict the checked entry instead of the true oldest. Random traffic over a small set of registers and addresses is compared against a register-keyed model. That traffic keeps the table full and exercises flush, clear-on-check and same-cycle interactions.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
  // Address bits below this index select a byte within one tracking granule.
  localparam int GRAN_LSB = 3;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } st_size_e;

  // Number of bytes minus one covered by a store of the given size code.
  function automatic logic [3:0] size_span(input logic [1:0] code);
    st_size_e s;
    s = st_size_e'(code);
    case (s)
      SZ_B1:   size_span = 4'd0;
      SZ_B2:   size_span = 4'd1;
      SZ_B4:   size_span = 4'd3;
      default: size_span = 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/slt_entry_array.sv
module slt_entry_array #(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int GRAN_W  = 29,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [REG_W-1:0]   ins_reg,
  input  logic [GRAN_W-1:0]  ins_gran,
  input  logic               core_v,
  input  logic [GRAN_W-1:0]  core_g0,
  input  logic [GRAN_W-1:0]  core_g1,
  input  logic               bus_v,
  input  logic [GRAN_W-1:0]  bus_g0,
  input  logic [GRAN_W-1:0]  bus_g1,
  input  logic [REG_W-1:0]   chk_reg,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] ld_match,
  output logic [ENTRIES-1:0] chk_match,
  output logic [ENTRIES-1:0] snoop_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              v_q;
    logic [REG_W-1:0]  r_q;
    logic [GRAN_W-1:0] g_q;
    logic              core_hit;
    logic              bus_hit;
    logic              kill;
    logic              write;

    assign core_hit = core_v && (g_q == core_g0 || g_q == core_g1);
    assign bus_hit  = bus_v && (g_q == bus_g0 || g_q == bus_g1);
    assign write    = ins_en && (ins_idx == IDX_W'(i));
    assign kill     = flush || core_hit || bus_hit ||
                      (clr_en && clr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= '0;
        g_q <= '0;
      end else if (write) begin
        // an insert overrides any same-cycle snoop, flush or clear
        v_q <= 1'b1;
        r_q <= ins_reg;
        g_q <= ins_gran;
      end else if (kill) begin
        v_q <= 1'b0;
      end
    end

    assign valid_vec[i] = v_q;
    assign snoop_vec[i] = v_q && (core_hit || bus_hit);
    assign ld_match[i]  = v_q && (r_q == ins_reg);
    assign chk_match[i] = v_q && (r_q == chk_reg);
  end

  // R6: at most one live entry ever claims a given register
  p_unique_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_match) && $onehot0(chk_match));

endmodule

// File: rtl/slt_lru.sv
module slt_lru #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_a_en,
  input  logic [IDX_W-1:0] touch_a_idx,
  input  logic             touch_b_en,
  input  logic [IDX_W-1:0] touch_b_idx,
  output logic [IDX_W-1:0] oldest_idx
);

  // Each entry holds a distinct rank; 0 is newest, ENTRIES-1 is oldest.
  logic [IDX_W-1:0]   age_q   [ENTRIES];
  logic [IDX_W-1:0]   age_mid [ENTRIES];
  logic [IDX_W-1:0]   age_nxt [ENTRIES];
  logic [IDX_W-1:0]   ref_a;
  logic [IDX_W-1:0]   ref_b;
  logic [ENTRIES-1:0] oldest_vec;

  assign ref_a = age_q[touch_a_idx];
  assign ref_b = age_mid[touch_b_idx];

  // first touch: the check hit
  always_comb begin
    for (int j = 0; j < ENTRIES; j++) begin
      if (touch_a_en && age_q[j] < ref_a) age_mid[j] = age_q[j] + 1'b1;
      else                                age_mid[j] = age_q[j];
    end
    if (touch_a_en) age_mid[touch_a_idx] = '0;
  end

  // second touch: the insert, so it ends up newest
  always_comb begin
    for (int j = 0; j < ENTRIES; j++) begin
      if (touch_b_en && age_mid[j] < ref_b) age_nxt[j] = age_mid[j] + 1'b1;
      else                                  age_nxt[j] = age_mid[j];
    end
    if (touch_b_en) age_nxt[touch_b_idx] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IDX_W'(j);
    end else begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= age_nxt[j];
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_old
    assign oldest_vec[i] = (age_q[i] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    oldest_idx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (oldest_vec[j]) oldest_idx = IDX_W'(j);
    end
  end

  // R7: the ranks stay a permutation, so exactly one entry is the oldest
  p_single_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_req,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ld_match,
  input  logic [IDX_W-1:0]   oldest_idx,
  output logic [IDX_W-1:0]   ins_idx
);

  logic             any_free;
  logic             hit;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] hit_idx;

  // lowest-numbered free entry
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (!valid_vec[j]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(j);
      end
    end
  end

  // one-hot to index of the entry already owned by the register
  always_comb begin
    hit_idx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (ld_match[j]) hit_idx = hit_idx | IDX_W'(j);
    end
  end

  assign hit = |ld_match;

  always_comb begin
    if (hit)           ins_idx = hit_idx;
    else if (any_free) ins_idx = free_idx;
    else               ins_idx = oldest_idx;
  end

  // R7: a new register never lands on a live entry while a free one exists
  p_free_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !hit && !(&valid_vec)) |-> !valid_vec[ins_idx]);

  // R6: an existing owner is always reused
  p_reuse_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && hit) |-> ld_match[ins_idx]);

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_reg,
  output logic              rsp_ok
);
  import spec_ld_pkg::*;

  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int GRAN_W = ADDR_W - GRAN_LSB;

  logic [ADDR_W-1:0]  st_last;
  logic [ADDR_W-1:0]  bus_last;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] ld_match;
  logic [ENTRIES-1:0] chk_match;
  logic [ENTRIES-1:0] snoop_vec;
  logic [IDX_W-1:0]   ins_idx;
  logic [IDX_W-1:0]   oldest_idx;
  logic [IDX_W-1:0]   chk_idx;
  logic               chk_hit;
  logic               clr_en;
  logic               unused_low;

  assign unused_low = ^ld_addr[GRAN_LSB-1:0];

  // last byte touched by each store; a store may straddle two granules
  assign st_last  = st_addr  + ADDR_W'(size_span(st_size));
  assign bus_last = bus_addr + ADDR_W'(size_span(bus_size));

  always_comb begin
    chk_idx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (chk_match[j]) chk_idx = chk_idx | IDX_W'(j);
    end
  end

  assign chk_hit = |chk_match;
  assign clr_en  = chk_valid && chk_clear && chk_hit;

  slt_entry_array #(
    .ENTRIES (ENTRIES),
    .REG_W   (REG_W),
    .GRAN_W  (GRAN_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ins_en    (ld_valid),
    .ins_idx   (ins_idx),
    .ins_reg   (ld_reg),
    .ins_gran  (ld_addr[ADDR_W-1:GRAN_LSB]),
    .core_v    (st_valid),
    .core_g0   (st_addr[ADDR_W-1:GRAN_LSB]),
    .core_g1   (st_last[ADDR_W-1:GRAN_LSB]),
    .bus_v     (bus_valid),
    .bus_g0    (bus_addr[ADDR_W-1:GRAN_LSB]),
    .bus_g1    (bus_last[ADDR_W-1:GRAN_LSB]),
    .chk_reg   (chk_reg),
    .clr_en    (clr_en),
    .clr_idx   (chk_idx),
    .valid_vec (valid_vec),
    .ld_match  (ld_match),
    .chk_match (chk_match),
    .snoop_vec (snoop_vec)
  );

  slt_lru #(
    .ENTRIES (ENTRIES)
  ) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_a_en  (chk_valid && chk_hit),
    .touch_a_idx (chk_idx),
    .touch_b_en  (ld_valid),
    .touch_b_idx (ins_idx),
    .oldest_idx  (oldest_idx)
  );

  slt_alloc #(
    .ENTRIES (ENTRIES)
  ) u_alloc (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_req    (ld_valid),
    .valid_vec  (valid_vec),
    .ld_match   (ld_match),
    .oldest_idx (oldest_idx),
    .ins_idx    (ins_idx)
  );

  // response uses the table state sampled before this cycle's updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_reg   <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= chk_valid;
      rsp_reg   <= chk_reg;
      rsp_ok    <= chk_valid && chk_hit;
    end
  end

  // R2: a safe answer only ever comes with a response strobe
  p_ok_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> rsp_valid);

  // R3 and R4: snooped entries are gone next cycle unless reloaded
  p_snoop_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (valid_vec & $past(snoop_vec)) == '0);

  // R8: the entry written by a load is live next cycle, whatever else happened
  p_insert_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> valid_vec[$past(ins_idx)]);

  // R9: a flush without a load empties the table
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !ld_valid) |=> valid_vec == '0);

  // R10: a clearing check leaves its entry invalid unless reloaded
  p_clear_on_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !ld_valid) |=> !valid_vec[$past(chk_idx)]);

endmodule

// File: tb/spec_load_tracker_tb.sv
`timescale 1ns/1ps
module spec_load_tracker_tb;
  localparam int E    = 32;
  localparam int RW   = 7;
  localparam int AW   = 32;
  localparam int NREG = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          ld_valid = 1'b0;
  logic [RW-1:0] ld_reg = '0;
  logic [AW-1:0] ld_addr = '0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [1:0]    st_size = '0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = '0;
  logic          chk_valid = 1'b0;
  logic [RW-1:0] chk_reg = '0;
  logic          chk_clear = 1'b0;
  logic          rsp_valid;
  logic [RW-1:0] rsp_reg;
  logic          rsp_ok;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model keyed by register
  bit            mv [NREG];
  logic [AW-4:0] mg [NREG];
  int            ms [NREG];
  int            tnow = 0;

  always #2.5 clk = ~clk;

  spec_load_tracker #(.ENTRIES(E), .REG_W(RW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
    .rsp_valid(rsp_valid), .rsp_reg(rsp_reg), .rsp_ok(rsp_ok)
  );

  function automatic bit store_hits(logic [AW-1:0] a, logic [1:0] sz, logic [AW-4:0] g);
    logic [AW-1:0] last;
    last = a + AW'((1 << sz) - 1);
    return (g == a[AW-1:3]) || (g == last[AW-1:3]);
  endfunction

  function automatic int live_count();
    int n = 0;
    for (int r = 0; r < NREG; r++) n += mv[r];
    return n;
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; ld_valid = 0; st_valid = 0; bus_valid = 0;
    chk_valid = 0; chk_clear = 0;
  endtask

  // one clock with the current inputs; model and response check
  task automatic cyc(string tag, bit use_lit, bit lit);
    bit exp_ok;
    bit present;
    int victim;
    int best;
    exp_ok  = mv[chk_reg];
    present = mv[ld_reg];
    victim  = -1;
    if (ld_valid && !present && live_count() == E) begin
      best = 32'h7fffffff;
      for (int r = 0; r < NREG; r++)
        if (mv[r] && ms[r] < best) begin best = ms[r]; victim = r; end
    end
    @(posedge clk);
    tnow += 2;
    if (chk_valid && exp_ok) begin
      if (chk_clear) mv[chk_reg] = 0;
      else           ms[chk_reg] = tnow;
    end
    for (int r = 0; r < NREG; r++) begin
      if (mv[r] && st_valid && store_hits(st_addr, st_size, mg[r])) mv[r] = 0;
      if (mv[r] && bus_valid && store_hits(bus_addr, bus_size, mg[r])) mv[r] = 0;
      if (flush) mv[r] = 0;
    end
    if (ld_valid) begin
      if (victim >= 0) mv[victim] = 0;
      mv[ld_reg] = 1;
      mg[ld_reg] = ld_addr[AW-1:3];
      ms[ld_reg] = tnow + 1;
    end
    @(negedge clk);
    if (chk_valid) begin
      if (use_lit) exp_ok = lit;
      check(rsp_valid && rsp_reg == chk_reg && rsp_ok == exp_ok,
            tag, int'(rsp_ok), int'(exp_ok));
    end
    idle();
  endtask

  task automatic do_ld(int r, int a);
    ld_valid = 1; ld_reg = RW'(r); ld_addr = AW'(a);
    cyc("load", 0, 0);
  endtask

  task automatic do_st(int a, int sz);
    st_valid = 1; st_addr = AW'(a); st_size = 2'(sz);
    cyc("store", 0, 0);
  endtask

  task automatic do_chk(int r, bit clr, string tag, bit lit);
    chk_valid = 1; chk_reg = RW'(r); chk_clear = clr;
    cyc(tag, 1, lit);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin mv[r] = 0; mg[r] = '0; ms[r] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    do_chk(5, 0, "R1 check after reset", 0);

    do_ld(3, 'h100);
    do_chk(3, 0, "R2 check after load", 1);
    do_st('h104, 0);
    do_chk(3, 0, "R3 byte store in granule", 0);
    do_ld(3, 'h100);
    do_st('h0FE, 2);
    do_chk(3, 0, "R3 unaligned store spans granule", 0);

    do_ld(4, 'h200);
    bus_valid = 1; bus_addr = 'h207; bus_size = 0;
    cyc("bus", 0, 0);
    do_chk(4, 0, "R4 bus store kills", 0);

    do_ld(5, 'h300);
    do_st('h308, 3);
    do_st('h2F8, 3);
    do_chk(5, 0, "R5 neighbour stores keep entry", 1);

    do_ld(6, 'h400);
    do_ld(6, 'h500);
    do_st('h400, 3);
    do_chk(6, 0, "R6 old address no longer snooped", 1);
    do_st('h500, 0);
    do_chk(6, 0, "R6 new address snooped", 0);

    ld_valid = 1; ld_reg = 7; ld_addr = 'h600;
    st_valid = 1; st_addr = 'h600; st_size = 3;
    cyc("same", 0, 0);
    do_chk(7, 0, "R8 insert beats same-cycle store", 1);

    do_ld(8, 'h700);
    flush = 1; ld_valid = 1; ld_reg = 9; ld_addr = 'h800;
    cyc("flush", 0, 0);
    do_chk(8, 0, "R9 flushed entry gone", 0);
    do_chk(9, 0, "R9 insert survives flush", 1);

    do_ld(10, 'h900);
    do_chk(10, 1, "R10 clearing check ok", 1);
    do_chk(10, 0, "R10 entry cleared", 0);

    do_ld(11, 'hA00);
    chk_valid = 1; chk_reg = 11; st_valid = 1; st_addr = 'hA00; st_size = 0;
    cyc("R11 check sees pre-store state", 1, 1);
    do_chk(11, 0, "R11 store applied afterwards", 0);

    flush = 1; cyc("flush", 0, 0);
    for (int r = 20; r < 20 + E; r++) do_ld(r, 'h1000 + r * 8);
    do_chk(20, 0, "R7 full table check", 1);
    do_ld(60, 'h3000);
    do_chk(21, 0, "R7 oldest evicted", 0);
    do_chk(20, 0, "R7 checked entry kept", 1);
    do_chk(60, 0, "R7 new entry present", 1);
    do_chk(22, 0, "R7 other entry kept", 1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = $urandom % 100;
      ld_valid  = ($urandom % 100) < 45;
      ld_reg    = RW'($urandom % 40);
      ld_addr   = AW'($urandom % 1024);
      st_valid  = ($urandom % 100) < 20;
      st_addr   = AW'($urandom % 1024);
      st_size   = 2'($urandom % 4);
      bus_valid = ($urandom % 100) < 10;
      bus_addr  = AW'($urandom % 1024);
      bus_size  = 2'($urandom % 4);
      chk_valid = ($urandom % 100) < 50;
      chk_reg   = RW'($urandom % 40);
      chk_clear = ($urandom % 100) < 15;
      flush     = (p == 0);
      cyc("R2 R7 R11 random", 0, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule